// File: doc/BRIEF.md
# Edge-Interval Acceleration Estimator

This block sits behind a quadrature decoder for one channel. Each count-update event from the decoder brings the signed displacement seen since the previous event. A free-running tick counter runs from the 100 MHz sampling clock, so one tick is 10 ns. It measures the interval between successive accepted events. When an event closes an interval, the block computes the instantaneous acceleration estimate a = Δx / Δt² in fixed point. The division uses a restoring divider that takes one quotient bit per cycle.

The result is packed into a 32-bit word, and the top four bits of that word hold a channel tag. The word is offered on a valid/ready stream that feeds a DMA engine. If the consumer is slow, only the newest estimate is kept and a flag marks the loss. If an interval runs longer than the counter can hold, a zero value is emitted with a timeout bit set.

Top module: `edge_accel_est`

## Requirements
- R1: While reset is low and on the first cycle after it, `evt_ready` is 1, `out_valid` is 0 and `out_overrun` is 0.
- R2: The first event accepted after reset only starts interval timing. It produces no packet, and its displacement is discarded.
- R3: The interval Δt is the number of clock cycles (10 ns ticks) between two accepted events. The value field is trunc(|Δx|·2^FRAC / Δt²) with the sign of Δx, in two's complement. Δx is the signed `evt_delta` of the closing event.
- R4: A value whose magnitude exceeds 2^26−1 is clamped to +(2^26−1) or −(2^26−1). The code 27'h4000000 never appears.
- R5: The tick counter saturates at 2^TW−1. An interval that reaches this count yields a packet with value 0 and the timeout bit set.
- R6: After a closing event is accepted, `evt_ready` is low for exactly DXW+FRAC cycles. The packet appears with `out_valid` on the cycle in which `evt_ready` returns high.
- R7: Packet layout: bits [31:28] hold CHAN_TAG, bit 27 is the timeout flag, and bits [26:0] hold the signed value.
- R8: A packet stays valid and unchanged until it is taken with `out_valid && out_ready`, unless a newer result replaces it.
- R9: When a new result is ready while an untaken packet is pending, the new result replaces it and `out_overrun` goes high. `out_overrun` clears when a packet is taken without a replacement in the same cycle.
- R10: An event offered while `evt_ready` is low is ignored. It neither restarts the interval nor produces a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Count-update event strobe |
| evt_ready | output | 1 | High when an event can be accepted |
| evt_delta | input | DXW (16) | Signed displacement carried by the event |
| out_valid | output | 1 | Packet available |
| out_ready | input | 1 | Consumer takes the packet |
| out_data | output | 32 | Tagged acceleration packet |
| out_overrun | output | 1 | Pending packet was replaced before being taken |

## Verification
A wrong tick count shows up in the value field of the very next packet, because Δt enters squared. A stuck divider step counter shows up as `evt_ready` returning early or late, within one divide time of the closing event. A wrong first-event flag produces a packet or suppresses one at the second event after reset. Every port is compared against a behavioural model on every cycle, so any of these faults is reported on the cycle it first reaches a port.

// File: rtl/edge_accel_est.sv
module edge_accel_est #(
  parameter int TW = 24,
  parameter int DXW = 16,
  parameter int FRAC = 24,
  parameter logic [3:0] CHAN_TAG = 4'd5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           evt_valid,
  output logic           evt_ready,
  input  logic [DXW-1:0] evt_delta,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [31:0]    out_data,
  output logic           out_overrun
);
  localparam int NW = DXW + FRAC;
  localparam int DW = 2 * TW;
  localparam int SW = $clog2(NW);
  localparam logic [TW-1:0] TMAX = '1;
  localparam logic [NW-1:0] VMAX = NW'(27'h3ffffff);

  logic [TW-1:0] cnt;
  logic          armed, busy, neg, tmo;
  logic [SW-1:0] step;
  logic [NW-1:0] num_q, quo;
  logic [DW-1:0] den;
  logic [DW:0]   rem;

  wire           take  = evt_valid && !busy;
  wire [DXW-1:0] dmag  = evt_delta[DXW-1] ? DXW'(-evt_delta) : evt_delta;
  wire [DW:0]    trial = {rem[DW-1:0], num_q[NW-1]};
  wire           fits  = trial >= {1'b0, den};
  wire [DW:0]    rem_n = fits ? trial - {1'b0, den} : trial;
  wire [NW-1:0]  quo_n = {quo[NW-2:0], fits};
  wire           last  = busy && (step == SW'(NW - 1));
  wire [26:0]    mag   = (quo_n > VMAX) ? 27'h3ffffff : quo_n[26:0];
  wire [26:0]    val   = tmo ? 27'd0 : (neg ? -mag : mag);

  assign evt_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      armed <= 1'b0;
      busy <= 1'b0;
      step <= '0;
      num_q <= '0;
      quo <= '0;
      den <= '0;
      rem <= '0;
      neg <= 1'b0;
      tmo <= 1'b0;
      out_valid <= 1'b0;
      out_data <= '0;
      out_overrun <= 1'b0;
    end else begin
      if (take) cnt <= TW'(1);
      else if (cnt != TMAX) cnt <= cnt + 1'b1;

      if (take) armed <= 1'b1;

      if (take && armed) begin
        busy <= 1'b1;
        step <= '0;
        num_q <= {dmag, {FRAC{1'b0}}};
        den <= DW'(cnt) * DW'(cnt);
        rem <= '0;
        quo <= '0;
        neg <= evt_delta[DXW-1];
        tmo <= (cnt == TMAX);
      end else if (busy) begin
        num_q <= num_q << 1;
        rem <= rem_n;
        quo <= quo_n;
        step <= step + 1'b1;
        if (last) busy <= 1'b0;
      end

      if (last) begin
        out_data <= {CHAN_TAG, tmo, val};
        out_valid <= 1'b1;
        out_overrun <= out_valid && !out_ready;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        out_overrun <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/edge_accel_est_chk.sv
module edge_accel_est_chk #(
  parameter logic [3:0] CHAN_TAG = 4'd5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_overrun
);
  assert_never_min_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[26:0] != 27'h4000000);

  assert_timeout_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_data[27] |-> out_data[26:0] == 27'd0);

  assert_packet_with_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> evt_ready);

  assert_tag_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[31:28] == CHAN_TAG);

  assert_hold_until_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && evt_ready |=> out_valid && $stable(out_data));

  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_overrun) |-> out_valid && $past(out_valid && !out_ready));
endmodule

bind edge_accel_est edge_accel_est_chk #(.CHAN_TAG(CHAN_TAG)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_ready(evt_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_overrun(out_overrun)
);

// File: tb/edge_accel_est_tb_top.sv
`timescale 1ns/1ps
module edge_accel_est_tb_top;
  localparam int TW = 10;
  localparam int DXW = 16;
  localparam int FRAC = 24;
  localparam int NW = DXW + FRAC;
  localparam logic [3:0] TAG = 4'h9;
  localparam longint TMAXV = (64'd1 << TW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, evt_valid = 1'b0, out_ready = 1'b1;
  logic [DXW-1:0] evt_delta = '0;
  logic evt_ready, out_valid, out_overrun;
  logic [31:0] out_data;

  edge_accel_est #(.TW(TW), .DXW(DXW), .FRAC(FRAC), .CHAN_TAG(TAG)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_delta(evt_delta), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_overrun(out_overrun));

  always #5 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit started = 0, stop_ready_rnd = 0;
  logic [15:0] lfsr = 16'hACE1;

  longint m_cnt = 0;
  int     m_left = 0;
  bit     m_armed = 0, m_busy = 0, m_valid = 0, m_ovr = 0;
  logic [31:0] m_data = '0, m_res = '0;

  function automatic logic [31:0] expect_pkt(longint dt, logic [DXW-1:0] d);
    longint dx, mag, q;
    logic [26:0] v;
    dx = longint'($signed(d));
    mag = (dx < 0) ? -dx : dx;
    q = (mag << FRAC) / (dt * dt);
    if (q > 67108863) q = 67108863;
    v = (dx < 0) ? 27'(-q) : 27'(q);
    if (dt == TMAXV) return {TAG, 1'b1, 27'd0};
    return {TAG, 1'b0, v};
  endfunction

  always @(posedge clk) begin
    bit acc, done;
    started = 1;
    if (!rst_n) begin
      m_cnt = 0; m_armed = 0; m_busy = 0; m_left = 0;
      m_valid = 0; m_ovr = 0; m_data = '0;
    end else begin
      acc = evt_valid && !m_busy;
      done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; done = 1; end
      end
      if (acc) begin
        if (m_armed) begin
          m_res = expect_pkt(m_cnt, evt_delta);
          m_busy = 1; m_left = NW;
        end
        m_armed = 1;
      end
      if (done) begin
        m_ovr = m_valid && !out_ready;
        m_valid = 1; m_data = m_res;
      end else if (m_valid && out_ready) begin
        m_valid = 0; m_ovr = 0;
      end
      if (acc) m_cnt = 1;
      else if (m_cnt != TMAXV) m_cnt++;
    end
  end

  task automatic cmp1(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      cmp1(rst_n ? "R6/R10 evt_ready" : "R1 evt_ready", 32'(evt_ready), 32'(!m_busy));
      cmp1(rst_n ? "R2/R8 out_valid" : "R1 out_valid", 32'(out_valid), 32'(m_valid));
      cmp1(rst_n ? "R9 out_overrun" : "R1 out_overrun", 32'(out_overrun), 32'(m_ovr));
      if (m_valid) begin
        if (m_data[27]) cmp1("R5 out_data", out_data, m_data);
        else if (m_data[26:0] == 27'h3ffffff || m_data[26:0] == 27'h4000001)
          cmp1("R4 out_data", out_data, m_data);
        else cmp1("R3/R7 out_data", out_data, m_data);
      end
    end
    if (!stop_ready_rnd) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= lfsr[0] | lfsr[1];
    end
  end

  task automatic ev(int gap, int dx);
    evt_valid = 1'b0;
    repeat (gap) @(negedge clk);
    evt_valid = 1'b1;
    evt_delta = DXW'(dx);
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    ev(3, 1234);        // R2 arms only
    ev(0, 5);           // dt=1, R4 positive clamp
    ev(60, -7000);      // R3 negative
    ev(45, -20000);     // R4 negative clamp
    ev(50, 0);          // R3 zero
    ev(10, 3);          // R10 dropped while busy
    ev(50, 300);        // R3, interval spans dropped event
    ev(1100, 42);       // R5 timeout
    ev(60, 32767);
    ev(41, -32768);     // R4 extreme
    for (int i = 0; i < 20; i++) ev(41 + (i * 37) % 200, (i * 2711) % 9000 - 4500);
    stop_ready_rnd = 1;
    @(negedge clk);
    out_ready = 1'b0;   // R9 overrun sequence
    for (int i = 0; i < 4; i++) ev(42, 100 * (i + 1));
    repeat (60) @(negedge clk);
    out_ready = 1'b1;   // R8 release
    repeat (5) @(negedge clk);
    rst_n = 1'b0;       // R1 mid-run reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ev(2, 10);
    ev(70, 900);
    repeat (60) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule